// File: doc/BRIEF.md
# Multi-candidate vote tally counter

This block keeps a running vote total for each of eight candidates. Every candidate has its own ballot line. When a line goes from low to high, the block registers one vote for that candidate. The line number is first turned into a candidate index, and the index is then decoded into one write enable per counter. All counters share a single incrementer.

A separate select input picks one candidate. That candidate's full total is driven out, and its low hex digit is also driven out as a seven-segment pattern for a display.

Votes are counted on rising edges only, so holding a ballot line high casts one vote. When several lines rise in the same cycle, the lowest-numbered line is the one counted.

Top module: `vote_tally`

## Requirements
- R1: While rst_ni is low, every candidate total reads 0. After reset release, every total reads 0 until a vote arrives, and seg_o shows the pattern for digit 0 (7'h3F).
- R2: A ballot line that was low at one rising clock edge and is high at the next adds exactly one to that candidate's total, at that same edge. All other totals stay unchanged.
- R3: A ballot line held high over several clock edges adds only one vote in total.
- R4: If several ballot lines rise at the same edge, only the lowest-numbered of them is counted.
- R5: detect_o is high while at least one ballot line is high now and was low at the previous clock edge. No total changes at an edge where detect_o was low.
- R6: total_o always equals the current total of the candidate whose index is on sel_i.
- R7: seg_o is the active-high pattern for the hex digit total_o[3:0]. Bit 0 is segment a and bit 6 is segment g. The digits 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R8: A lower-numbered line that is held high, and so is not rising, does not stop a higher-numbered line that rises from being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ballot_i | input | 8 | One ballot line per candidate, synchronous to clk_i |
| sel_i | input | 3 | Index of the candidate to display |
| detect_o | output | 1 | A ballot line rose in this cycle |
| total_o | output | 32 | Total of the selected candidate |
| seg_o | output | 7 | Seven-segment pattern of the low hex digit of total_o |

## Verification
All 255 non-zero combinations of simultaneously rising lines are applied from an all-low state. Each combination shows whether the lowest-index rule and the single-writer decode pick the right counter. A line held over many cycles separates edge counting from level counting. A held low line combined with a rising higher line tells "rising" apart from "high". Sweeping sel_i over every candidate after each phase checks all totals and their segment patterns against an arithmetic model, as the low digit wraps through all sixteen hex values.

// File: rtl/vote_pkg.sv
package vote_pkg;
  // Active-high segments, bit0 = a .. bit6 = g
  function automatic logic [6:0] hex_to_seg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/vote_edge_enc.sv
module vote_edge_enc #(
  parameter int N_CAND = 8,
  localparam int IDX_W = $clog2(N_CAND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CAND-1:0] ballot_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  logic [N_CAND-1:0] prev_q;
  logic [N_CAND-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= ballot_i;
  end

  assign rise = ballot_i & ~prev_q;

  // lowest rising line wins
  always_comb begin
    idx_o = '0;
    for (int k = N_CAND - 1; k >= 0; k--) begin
      if (rise[k]) idx_o = IDX_W'(k);
    end
  end

  assign valid_o = |rise;

  assert_encoded_was_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ballot_i[idx_o] && !prev_q[idx_o]));

  assert_no_lower_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((rise & ((N_CAND'(1) << idx_o) - N_CAND'(1))) == '0));
endmodule

// File: rtl/vote_we_dec.sv
module vote_we_dec #(
  parameter int N_CAND = 8,
  localparam int IDX_W = $clog2(N_CAND)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  output logic [N_CAND-1:0] we_o
);
  for (genvar k = 0; k < N_CAND; k++) begin : g_we
    assign we_o[k] = valid_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/vote_cnt_bank.sv
module vote_cnt_bank #(
  parameter int N_CAND = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(N_CAND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CAND-1:0] we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [CNT_W-1:0]  total_o
);
  logic [CNT_W-1:0] cnt_q [N_CAND];
  logic [CNT_W-1:0] inc;

  // single shared incrementer
  assign inc = cnt_q[idx_i] + CNT_W'(1);

  for (genvar k = 0; k < N_CAND; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q[k] <= '0;
      else if (we_i[k]) cnt_q[k] <= inc;
    end

    assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[k] != $past(cnt_q[k])) |-> (cnt_q[k] == $past(cnt_q[k]) + CNT_W'(1)));

    assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(we_i[k]) |-> (cnt_q[k] == $past(cnt_q[k])));
  end

  assign total_o = cnt_q[sel_i];

  assert_one_writer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(we_i) <= 1);
endmodule

// File: rtl/vote_tally.sv
module vote_tally #(
  parameter int N_CAND = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(N_CAND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CAND-1:0] ballot_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic              detect_o,
  output logic [CNT_W-1:0]  total_o,
  output logic [6:0]        seg_o
);
  import vote_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic              valid;
  logic [N_CAND-1:0] we;

  vote_edge_enc #(.N_CAND(N_CAND)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ballot_i(ballot_i),
    .idx_o   (idx),
    .valid_o (valid)
  );

  vote_we_dec #(.N_CAND(N_CAND)) u_dec (
    .idx_i  (idx),
    .valid_i(valid),
    .we_o   (we)
  );

  vote_cnt_bank #(.N_CAND(N_CAND), .CNT_W(CNT_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .idx_i  (idx),
    .sel_i  (sel_i),
    .total_o(total_o)
  );

  assign detect_o = valid;
  assign seg_o    = hex_to_seg(total_o[3:0]);

  assert_seg_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_o[3:0] == 4'h0) |-> (seg_o == 7'h3F));

  assert_quiet_no_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_o |-> (we == '0));
endmodule

// File: tb/vote_tally_tb.sv
module vote_tally_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ballot = '0;
  logic [2:0]  sel = '0;
  logic        detect;
  logic [31:0] total;
  logic [6:0]  seg;

  int n_vec = 0;
  int n_bad = 0;
  int exp_cnt [N];
  logic [7:0] prev_m = '0;

  always #4 clk = ~clk;

  vote_tally dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ballot_i(ballot), .sel_i(sel),
    .detect_o(detect), .total_o(total), .seg_o(seg)
  );

  function automatic logic [6:0] seg_ref(input logic [3:0] d);
    case (d)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6/R7 sweep over all candidates
  task automatic sweep(input string req);
    for (int c = 0; c < N; c++) begin
      sel = 3'(c);
      #1;
      chk({req, " total (R6)"}, total, 32'(exp_cnt[c]));
      chk({req, " seg (R7)"}, {25'd0, seg}, {25'd0, seg_ref(4'(exp_cnt[c]))});
    end
  endtask

  // drive one cycle at negedge, check detect, update model at posedge
  task automatic step(input logic [7:0] pat);
    logic [7:0] r;
    @(negedge clk);
    ballot = pat;
    #1;
    r = pat & ~prev_m;
    chk("R5 detect", {31'd0, detect}, {31'd0, (r != 0)});
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      if (r[k]) begin
        exp_cnt[k]++;
        break;
      end
    end
    prev_m = pat;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) exp_cnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sweep("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 after reset");
    chk("R1 detect idle", {31'd0, detect}, 32'd0);

    // R2: single-line votes, one per candidate, check the winner in that cycle
    for (int c = 0; c < N; c++) begin
      step(8'(1 << c));
      sel = 3'(c);
      #1;
      chk("R2 single vote", total, 32'(exp_cnt[c]));
      step(8'h00);
      chk("R5 idle edge keeps totals", total, 32'(exp_cnt[c]));
    end
    sweep("R2 after singles");

    // R4: every non-zero rising combination from all-low
    for (int p = 1; p < 256; p++) begin
      step(8'(p));
      step(8'h00);
    end
    sweep("R4 all combos");

    // R3: hold line 5 for many cycles
    for (int i = 0; i < 10; i++) step(8'h20);
    step(8'h00);
    sel = 3'd5;
    #1;
    chk("R3 held counts once", total, 32'(exp_cnt[5]));

    // R8: line 0 held while line 3 rises
    step(8'h01);
    step(8'h01);
    step(8'h09);
    sel = 3'd3;
    #1;
    chk("R8 held lower does not block", total, 32'(exp_cnt[3]));
    step(8'h00);
    sweep("R8 final");

    // R7: walk candidate 6 through all hex digits
    for (int i = 0; i < 20; i++) begin
      step(8'h40);
      step(8'h00);
      sel = 3'd6;
      #1;
      chk("R7 digit walk", {25'd0, seg}, {25'd0, seg_ref(4'(exp_cnt[6]))});
    end
    sweep("R7 final");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule